// File: doc/BRIEF.md
# Interval Timer Bus Register Interface

This block sits between a processor bus and the three counting cores of an interval timer. A two-bit address picks one of the three channel data ports or the shared control port. Chip-select, read and write strobes qualify every access. Control words set each channel's counting mode, number format and byte access order. Channel writes build the 16-bit initial count that the block hands to its core, with a one-cycle load pulse. Channel reads return either the live count from the core or a frozen snapshot taken by a latch command.

A read-back command arms a one-shot status byte for any set of channels. The status byte carries the live OUT level of the channel and a flag that shows a written count has not yet been taken by the core. It also carries the six configuration bits stored for that channel. All read data leaves the block through a register, one cycle after the read strobe.

Top module: `tmr_regif`

## Requirements
- R1: A control write (address 3) with D7..D6 = channel 0..2 and D5..D4 not 00 stores D5..D0 for that channel. `ch_mode` equals D3..D1, except that codes 6 and 7 are reported as 2 and 3. `ch_bcd` equals D0.
- R2: With access code 01, one data write sets the count to {8'h00, byte}. With access code 10, one data write sets it to {byte, 8'h00}. In both cases `ch_load` pulses for exactly the one cycle that follows the write edge.
- R3: With access code 11, the first data write fills the low byte and the second fills the high byte. `ch_load` pulses only after the second write.
- R4: A control write for a channel resets its byte toggle, so that the next access with code 11 is treated as a low byte.
- R5: Reads with no latch or status pending return the live count: the low byte for code 01, the high byte for code 10, and low then high alternately for code 11. `rdata` is updated at the clock edge that samples the read.
- R6: A control write with D5..D4 = 00 (latch) captures the channel's current count. Reads then return the captured value whatever the live count does. The capture is released after the high byte in code 11, or after the single byte in codes 01 and 10.
- R7: A latch command that arrives while a capture is still unread has no effect.
- R8: A control write with D7..D6 = 11 is a read-back command. Bits D1, D2 and D3 select channels 0, 1 and 2. The next read of each selected channel returns one status byte: bit 7 is the OUT level, bit 6 is the null-count flag, and bits 5..0 are the stored D5..D0. Later reads return count bytes again.
- R9: The null-count flag is set by a control write and by a completed count write. It is cleared by a `ch_loaded` pulse. When a set and a clear fall in the same cycle, the flag ends set.
- R10: Accesses without `cs`, or with `rd` and `wr` both high, change nothing. A read of address 3 returns 8'h00. A latch command leaves the stored configuration unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 2 | 0..2 channel data port, 3 control port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| ch_cur | input | 48 | Live count of each core, 16 bits per channel |
| ch_out | input | 3 | OUT level of each core |
| ch_loaded | input | 3 | Core has taken the written count |
| ch_load | output | 3 | One-cycle pulse: new count ready |
| ch_count | output | 48 | Initial count per channel |
| ch_mode | output | 9 | Folded counting mode, 3 bits per channel |
| ch_bcd | output | 3 | BCD counting select per channel |

## Verification
Two events can land on the null-count flag in the same cycle. A count write that completes sets it, and the core's `ch_loaded` acknowledgement clears it. The bench forces both into one clock by raising `ch_loaded` during the write strobe. It then issues a read-back command and requires bit 6 of the status byte to be 1. A second collision comes from the live count moving while a capture is held. The bench changes `ch_cur` between the two byte reads and between repeated latch commands, and requires every returned byte to come from the first snapshot.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_LOHI  = 2'b11
  } acc_e;

  // codes 6 and 7 alias onto 2 and 3
  function automatic logic [2:0] fold_mode(input logic [2:0] m);
    return m[1] ? {1'b0, m[1:0]} : m;
  endfunction
endpackage

// File: rtl/tmr_dec.sv
module tmr_dec #(
  parameter int NCH = 3,
  parameter int DW  = 8
) (
  input  logic           cs,
  input  logic           rd,
  input  logic           wr,
  input  logic [1:0]     addr,
  input  logic [DW-1:0]  wdata,
  output logic [NCH-1:0] ctl_we,
  output logic [NCH-1:0] lat_cmd,
  output logic [NCH-1:0] stat_cmd,
  output logic [NCH-1:0] wr_en,
  output logic [NCH-1:0] rd_en,
  output logic           rd_ctl
);
  import tmr_pkg::*;
  logic wr_q, rd_q, ctl_sel;
  acc_e acc;

  always_comb begin
    wr_q    = cs && wr && !rd;
    rd_q    = cs && rd && !wr;
    ctl_sel = (addr == 2'd3);
    acc     = acc_e'(wdata[5:4]);
    rd_ctl  = rd_q && ctl_sel;
    for (int i = 0; i < NCH; i++) begin
      wr_en[i]    = wr_q && !ctl_sel && (addr == 2'(i));
      rd_en[i]    = rd_q && !ctl_sel && (addr == 2'(i));
      ctl_we[i]   = wr_q && ctl_sel && (wdata[7:6] == 2'(i)) && (acc != ACC_LATCH);
      lat_cmd[i]  = wr_q && ctl_sel && (wdata[7:6] == 2'(i)) && (acc == ACC_LATCH);
      stat_cmd[i] = wr_q && ctl_sel && (wdata[7:6] == 2'b11) && wdata[i+1];
    end
  end
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs #(
  parameter int DW = 8,
  localparam int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_we,
  input  logic          lat_cmd,
  input  logic          stat_cmd,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  input  logic [CW-1:0] cur,
  input  logic          out_lvl,
  input  logic          core_loaded,
  output logic [DW-1:0] rd_byte,
  output logic          load,
  output logic [CW-1:0] count,
  output logic [2:0]    mode,
  output logic          bcd
);
  import tmr_pkg::*;
  logic [5:0]    ctl;
  logic          tog, lat_v, st_v, nullc;
  logic [CW-1:0] lat_val, src;
  logic [DW-1:0] st_val;
  acc_e          acc;

  assign acc  = acc_e'(ctl[5:4]);
  assign mode = fold_mode(ctl[3:1]);
  assign bcd  = ctl[0];

  always_comb begin
    src = lat_v ? lat_val : cur;
    if (st_v)                                   rd_byte = st_val;
    else if (acc == ACC_HI || (acc == ACC_LOHI && tog)) rd_byte = src[CW-1:DW];
    else                                        rd_byte = src[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl <= '0; tog <= 1'b0; lat_v <= 1'b0; st_v <= 1'b0; nullc <= 1'b0;
      lat_val <= '0; st_val <= '0; count <= '0; load <= 1'b0;
    end else begin
      load <= 1'b0;
      if (core_loaded) nullc <= 1'b0;
      if (ctl_we) begin
        ctl   <= wdata[5:0];
        tog   <= 1'b0;
        lat_v <= 1'b0;
        nullc <= 1'b1;
      end
      if (lat_cmd && !lat_v) begin
        lat_val <= cur;
        lat_v   <= 1'b1;
      end
      if (stat_cmd && !st_v) begin
        st_val <= {out_lvl, nullc, ctl};
        st_v   <= 1'b1;
      end
      if (wr_en) begin
        unique case (acc)
          ACC_LO: begin count <= {{DW{1'b0}}, wdata}; load <= 1'b1; nullc <= 1'b1; end
          ACC_HI: begin count <= {wdata, {DW{1'b0}}}; load <= 1'b1; nullc <= 1'b1; end
          ACC_LOHI: begin
            if (!tog) count[DW-1:0] <= wdata;
            else begin
              count[CW-1:DW] <= wdata; load <= 1'b1; nullc <= 1'b1;
            end
            tog <= ~tog;
          end
          default: ;
        endcase
      end
      if (rd_en) begin
        if (st_v) st_v <= 1'b0;
        else begin
          if (acc == ACC_LOHI) tog <= ~tog;
          if (lat_v && (acc != ACC_LOHI || tog)) lat_v <= 1'b0;
        end
      end
    end
  end

  // R2
  load_after_write_chk: assert property (@(posedge clk) disable iff (rst) load |-> $past(wr_en));
  // R9
  null_set_chk: assert property (@(posedge clk) disable iff (rst) ctl_we |=> nullc);
  // R4
  toggle_reset_chk: assert property (@(posedge clk) disable iff (rst) ctl_we |=> !tog);
  // R6
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (lat_v && !ctl_we) |=> $stable(lat_val));
  // R1
  ctl_store_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_we |=> (ctl == $past(wdata[5:0])));
endmodule

// File: rtl/tmr_regif.sv
module tmr_regif #(
  parameter int NCH = 3,
  parameter int DW  = 8,
  localparam int CW = 2 * DW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs,
  input  logic             rd,
  input  logic             wr,
  input  logic [1:0]       addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic [NCH*CW-1:0] ch_cur,
  input  logic [NCH-1:0]   ch_out,
  input  logic [NCH-1:0]   ch_loaded,
  output logic [NCH-1:0]   ch_load,
  output logic [NCH*CW-1:0] ch_count,
  output logic [NCH*3-1:0] ch_mode,
  output logic [NCH-1:0]   ch_bcd
);
  logic [NCH-1:0] ctl_we, lat_cmd, stat_cmd, wr_en, rd_en;
  logic           rd_ctl;
  logic [DW-1:0]  rd_byte [NCH];
  logic [DW-1:0]  byte_mux;

  tmr_dec #(.NCH(NCH), .DW(DW)) u_dec (
    .cs(cs), .rd(rd), .wr(wr), .addr(addr), .wdata(wdata),
    .ctl_we(ctl_we), .lat_cmd(lat_cmd), .stat_cmd(stat_cmd),
    .wr_en(wr_en), .rd_en(rd_en), .rd_ctl(rd_ctl)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tmr_chan_regs #(.DW(DW)) u_ch (
      .clk(clk), .rst(rst),
      .ctl_we(ctl_we[g]), .lat_cmd(lat_cmd[g]), .stat_cmd(stat_cmd[g]),
      .wr_en(wr_en[g]), .rd_en(rd_en[g]), .wdata(wdata),
      .cur(ch_cur[g*CW +: CW]), .out_lvl(ch_out[g]), .core_loaded(ch_loaded[g]),
      .rd_byte(rd_byte[g]), .load(ch_load[g]),
      .count(ch_count[g*CW +: CW]), .mode(ch_mode[g*3 +: 3]), .bcd(ch_bcd[g])
    );
  end

  always_comb begin
    byte_mux = '0;
    for (int i = 0; i < NCH; i++)
      if (rd_en[i]) byte_mux = rd_byte[i];
  end

  always_ff @(posedge clk) begin
    if (rst)                rdata <= '0;
    else if (rd_ctl)        rdata <= '0;
    else if (|rd_en)        rdata <= byte_mux;
  end

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(cs && rd && !wr) |=> $stable(rdata));
  // R10
  one_target_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl_we, lat_cmd, wr_en, rd_en, rd_ctl}));
endmodule

// File: tb/tmr_regif_bench.sv
module tmr_regif_bench;
  localparam int CLK_NS = 10;
  logic clk = 1'b0, rst = 1'b1, cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0, rdata;
  logic [47:0] ch_cur = '0, ch_count;
  logic [2:0]  ch_out = '0, ch_loaded = '0, ch_load, ch_bcd;
  logic [8:0]  ch_mode;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  tmr_regif u_tmr_regif (
    .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ch_cur(ch_cur), .ch_out(ch_out), .ch_loaded(ch_loaded),
    .ch_load(ch_load), .ch_count(ch_count), .ch_mode(ch_mode), .ch_bcd(ch_bcd)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1; rd = 1; addr = a;
    @(negedge clk); cs = 0; rd = 0; d = rdata;
  endtask

  task automatic pulse_loaded(input int c);
    @(negedge clk); ch_loaded[c] = 1;
    @(negedge clk); ch_loaded[c] = 0;
  endtask

  function automatic logic [2:0] exp_mode(input logic [2:0] m);
    return (m >= 3'd6) ? m - 3'd4 : m;
  endfunction

  initial begin
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R5 reset rdata", rdata, 0);
    chk("R2 reset load", ch_load, 0);
    chk("R1 reset mode", ch_mode, 0);

    // R1 sweep of every mode and format on every channel
    for (int c = 0; c < 3; c++)
      for (int m = 0; m < 8; m++)
        for (int f = 0; f < 2; f++) begin
          bus_wr(2'd3, {2'(c), 2'b11, 3'(m), 1'(f)});
          chk("R1 mode", ch_mode[c*3 +: 3], exp_mode(3'(m)));
          chk("R1 bcd", ch_bcd[c], f);
        end

    for (int c = 0; c < 3; c++) begin
      // R2 single-byte writes
      bus_wr(2'd3, {2'(c), 2'b01, 4'b0000});
      bus_wr(2'(c), 8'hA5 ^ 8'(c));
      chk("R2 lo load", ch_load[c], 1);
      chk("R2 lo count", ch_count[c*16 +: 16], {8'h00, 8'hA5 ^ 8'(c)});
      @(negedge clk);
      chk("R2 load one cycle", ch_load[c], 0);
      bus_wr(2'd3, {2'(c), 2'b10, 4'b0000});
      bus_wr(2'(c), 8'h3C + 8'(c));
      chk("R2 hi load", ch_load[c], 1);
      chk("R2 hi count", ch_count[c*16 +: 16], {8'h3C + 8'(c), 8'h00});
      // R3 two-byte write
      bus_wr(2'd3, {2'(c), 2'b11, 4'b0100});
      bus_wr(2'(c), 8'h21);
      chk("R3 no load after low", ch_load[c], 0);
      bus_wr(2'(c), 8'h43 + 8'(c));
      chk("R3 load after high", ch_load[c], 1);
      chk("R3 count", ch_count[c*16 +: 16], {8'h43 + 8'(c), 8'h21});
      // R4 control word resets toggle mid-sequence
      bus_wr(2'(c), 8'h11);
      bus_wr(2'd3, {2'(c), 2'b11, 4'b0100});
      bus_wr(2'(c), 8'h22);
      chk("R4 no load", ch_load[c], 0);
      bus_wr(2'(c), 8'h33);
      chk("R4 count", ch_count[c*16 +: 16], 16'h3322);
      // R5 live reads
      ch_cur[c*16 +: 16] = 16'hBE00 + 16'(c);
      bus_rd(2'(c), b); chk("R5 lohi low", b, 8'(c));
      bus_rd(2'(c), b); chk("R5 lohi high", b, 8'hBE);
      bus_wr(2'd3, {2'(c), 2'b01, 4'b0000});
      bus_rd(2'(c), b); chk("R5 lo only", b, 8'(c));
      bus_wr(2'd3, {2'(c), 2'b10, 4'b0000});
      bus_rd(2'(c), b); chk("R5 hi only", b, 8'hBE);
      // R6 / R7 latch in two-byte mode
      bus_wr(2'd3, {2'(c), 2'b11, 4'b0000});
      ch_cur[c*16 +: 16] = 16'h1234;
      bus_wr(2'd3, {2'(c), 2'b00, 4'b0000});
      chk("R10 latch keeps config", ch_mode[c*3 +: 3], 0);
      ch_cur[c*16 +: 16] = 16'h5678;
      bus_rd(2'(c), b); chk("R6 latched low", b, 8'h34);
      bus_wr(2'd3, {2'(c), 2'b00, 4'b0000});
      ch_cur[c*16 +: 16] = 16'h9ABC;
      bus_rd(2'(c), b); chk("R7 latched high", b, 8'h12);
      bus_rd(2'(c), b); chk("R6 released", b, 8'hBC);
      bus_rd(2'(c), b);
      // R7 latch in low-only mode
      bus_wr(2'd3, {2'(c), 2'b01, 4'b0000});
      ch_cur[c*16 +: 16] = 16'hABCD;
      bus_wr(2'd3, {2'(c), 2'b00, 4'b0000});
      ch_cur[c*16 +: 16] = 16'h0011;
      bus_wr(2'd3, {2'(c), 2'b00, 4'b0000});
      bus_rd(2'(c), b); chk("R7 ignored relatch", b, 8'hCD);
      bus_rd(2'(c), b); chk("R6 released lo", b, 8'h11);
      // R8 status read-back, R9 flag
      ch_out[c] = 1;
      bus_wr(2'd3, {2'(c), 2'b11, 3'b011, 1'b0});
      bus_wr(2'd3, 8'hC0 | (8'h02 << c));
      bus_rd(2'(c), b); chk("R8 status", b, 8'hF6);
      pulse_loaded(c);
      bus_wr(2'd3, 8'hC0 | (8'h02 << c));
      bus_rd(2'(c), b); chk("R9 cleared by loaded", b, 8'hB6);
      ch_out[c] = 0;
      ch_cur[c*16 +: 16] = 16'h7E5A;
      bus_wr(2'd3, 8'hC0 | (8'h02 << c));
      bus_rd(2'(c), b); chk("R8 out low", b, 8'h36);
      bus_rd(2'(c), b); chk("R8 then count", b, 8'h5A);
      // R9 set and clear in the same cycle
      bus_wr(2'd3, {2'(c), 2'b01, 4'b0000});
      pulse_loaded(c);
      @(negedge clk); cs = 1; wr = 1; addr = 2'(c); wdata = 8'h66; ch_loaded[c] = 1;
      @(negedge clk); cs = 0; wr = 0; ch_loaded[c] = 0;
      bus_wr(2'd3, 8'hC0 | (8'h02 << c));
      bus_rd(2'(c), b); chk("R9 set wins", b[6], 1);
    end

    // R10 ignored accesses
    bus_wr(2'd3, 8'b00_01_0000);
    bus_wr(2'd0, 8'h55);
    @(negedge clk); wr = 1; addr = 2'd0; wdata = 8'h99;
    @(negedge clk); wr = 0;
    chk("R10 no cs write", ch_count[15:0], 16'h0055);
    ch_cur[15:0] = 16'h00E1;
    bus_rd(2'd0, b);
    @(negedge clk); rd = 1; addr = 2'd0; ch_cur[15:0] = 16'h00F2;
    @(negedge clk); rd = 0;
    chk("R10 no cs read", rdata, 8'hE1);
    @(negedge clk); cs = 1; rd = 1; wr = 1; addr = 2'd0; wdata = 8'h77;
    @(negedge clk); cs = 0; rd = 0; wr = 0;
    chk("R10 rd+wr load", ch_load[0], 0);
    chk("R10 rd+wr count", ch_count[15:0], 16'h0055);
    chk("R10 rd+wr rdata", rdata, 8'hE1);
    bus_rd(2'd3, b); chk("R10 control read", b, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule